// File: doc/BRIEF.md
# Strided Frame Line Fetch Sequencer

This block walks a frame held in memory one line at a time and issues burst read requests that a pixel FIFO downstream collects. A frame-start pulse captures the first line address, the line length in bytes, a signed line pitch, the number of lines and a bus options word. From these it works out the address one pitch past the last line and stops once the walk reaches that address. Each line is cut into bursts whose size comes from a flag field. The final burst of a line is cut short to the bytes that remain, and the next line then begins at its own start address.

A credit counter tracks requests that are still waiting for a response and holds new requests back once the programmed limit is reached. An abort moves the line pointer to the end address, stops the walk and sends a one-cycle flush to the FIFO. When the last outstanding response comes back with the walk stopped, the block pulses a fetch-complete interrupt. This happens after a normal end and after an abort alike.

Top module: `line_fetch_seq`

## Requirements
- R1: After reset, busy, req_valid, fetch_done and fifo_flush are low and inflight is zero.
- R2: A frame start accepted while idle issues the first request at the base address. Line n (counting from 0) starts at base + n × pitch. The walk stops after the line whose successor address equals base + line_count × pitch.
- R3: The pitch is a two's-complement value, so a negative pitch fetches lines at falling addresses.
- R4: The burst flags are bus_opts[4:0], and k is the index of their highest set bit. The burst is 2^(k−1) beats for k ≥ 1, 1 beat for k = 0, and 16 beats when the flags are all zero. Each beat is 8 bytes.
- R5: A line is requested in full bursts from its start address upward. Its last request carries only the remaining bytes, so the request sizes add up to the line length.
- R6: The limit on outstanding requests is bus_opts[11:8]. Once inflight equals the limit, req_valid stays low until a response arrives.
- R7: A frame start with a zero limit field or a zero line length is ignored, and the block stays idle.
- R8: An abort drops busy and req_valid in the next cycle and raises fifo_flush for exactly that one cycle. No request follows until the next frame start.
- R9: fetch_done pulses once, one cycle after the response that brings inflight to zero while the block is not busy.
- R10: A frame start that arrives while busy has no effect on the frame in progress.
- R11: While req_valid is high and req_ready low, req_valid, req_addr and req_bytes hold their values.
- R12: When base + line_count × pitch equals the base address (for example with a line count of zero), a frame start issues no request and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse that begins a frame walk |
| abort | input | 1 | Stops the walk and flushes the FIFO |
| base_addr | input | ADDR_W | Address of the first line |
| line_len | input | LEN_W | Bytes fetched per line |
| line_pitch | input | PITCH_W | Signed distance between line starts |
| line_count | input | CNT_W | Number of lines |
| bus_opts | input | 32 | Burst flags [4:0] and outstanding limit [11:8] |
| req_valid | output | 1 | Read request available |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Request start address |
| req_bytes | output | BYTES_W | Request size in bytes |
| rsp_valid | input | 1 | One request has completed |
| busy | output | 1 | Line walk in progress |
| inflight | output | LIMIT_W | Requests awaiting a response |
| fetch_done | output | 1 | Fetch-complete interrupt pulse |
| fifo_flush | output | 1 | One-cycle FIFO flush after an abort |

## Verification
Line lengths are chosen to fit one burst, to split into several full bursts plus a short remainder, and to split exactly into full bursts. This separates the line-advance decision from the burst-split decision. Positive and negative pitches check that the end address uses signed arithmetic. A walk of zero lines shows that no request escapes when the start address already equals the end address. A tight outstanding limit with responses withheld, an abort in mid-frame with responses still pending, and a frame start while busy show that credit, abort and completion interact correctly. Irregular ready patterns make the request hold its values across stalls.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int OPTS_W    = 32;
  localparam int FLAG_LSB  = 0;
  localparam int FLAG_W    = 5;
  localparam int LIMIT_LSB = 8;
  localparam int LIMIT_W   = 4;

  // log2 of the burst length in beats, decoded from the flag field
  function automatic int burst_log2(input logic [FLAG_W-1:0] flags,
                                    input int max_log2);
    int top;
    int lg;
    top = -1;
    for (int i = 0; i < FLAG_W; i++)
      if (flags[i]) top = i;
    if (top < 0)       lg = max_log2;
    else if (top == 0) lg = 0;
    else               lg = top - 1;
    if (lg > max_log2) lg = max_log2;
    return lg;
  endfunction
endpackage

// File: rtl/lfs_burst_decode.sv
module lfs_burst_decode
  import lfs_pkg::*;
#(
  parameter int PORT_BYTES     = 8,
  parameter int MAX_BURST_LOG2 = 4,
  parameter int BYTES_W        = 8
) (
  input  logic [FLAG_W-1:0]  flags,
  output logic [BYTES_W-1:0] burst_bytes
);
  always_comb begin
    burst_bytes = BYTES_W'(PORT_BYTES) << burst_log2(flags, MAX_BURST_LOG2);
  end
endmodule

// File: rtl/lfs_addr_walker.sv
module lfs_addr_walker #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int PITCH_W = 20,
  parameter int CNT_W   = 13,
  parameter int BYTES_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      abort,
  input  logic [ADDR_W-1:0]         base,
  input  logic signed [PITCH_W-1:0] pitch,
  input  logic [CNT_W-1:0]          count,
  input  logic [LEN_W-1:0]          line_len,
  input  logic [BYTES_W-1:0]        burst_bytes,
  input  logic                      issue,
  output logic                      run,
  output logic [ADDR_W-1:0]         cur_addr,
  output logic [BYTES_W-1:0]        cur_bytes,
  output logic                      line_end
);
  function automatic logic [ADDR_W-1:0] widen_pitch(input logic signed [PITCH_W-1:0] p);
    return {{(ADDR_W-PITCH_W){p[PITCH_W-1]}}, p};
  endfunction

  function automatic logic [ADDR_W-1:0] stop_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [CNT_W-1:0] n,
                                                   input logic signed [PITCH_W-1:0] p);
    logic [ADDR_W-1:0] prod;
    prod = ADDR_W'(n) * widen_pitch(p);
    return b + prod;
  endfunction

  logic [ADDR_W-1:0] line_q, end_q, step_q;
  logic [LEN_W-1:0]  len_q, chunk_q, offs_q;
  logic              run_q;

  logic [LEN_W-1:0]  remain, take;
  logic              last_chunk;
  logic [ADDR_W-1:0] next_line, start_end;

  always_comb begin
    remain     = len_q - offs_q;
    last_chunk = remain <= chunk_q;
    take       = last_chunk ? remain : chunk_q;
    next_line  = line_q + step_q;
    start_end  = stop_addr(base, count, pitch);
  end

  assign run       = run_q;
  assign cur_addr  = line_q + ADDR_W'(offs_q);
  assign cur_bytes = BYTES_W'(take);
  assign line_end  = issue && run_q && last_chunk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      end_q   <= '0;
      step_q  <= '0;
      len_q   <= '0;
      chunk_q <= '0;
      offs_q  <= '0;
      run_q   <= 1'b0;
    end else if (abort) begin
      line_q <= end_q;
      offs_q <= '0;
      run_q  <= 1'b0;
    end else if (start) begin
      line_q  <= base;
      end_q   <= start_end;
      step_q  <= widen_pitch(pitch);
      len_q   <= line_len;
      chunk_q <= LEN_W'(burst_bytes);
      offs_q  <= '0;
      run_q   <= base != start_end;
    end else if (issue && run_q) begin
      if (last_chunk) begin
        offs_q <= '0;
        line_q <= next_line;
        if (next_line == end_q) run_q <= 1'b0;
      end else begin
        offs_q <= offs_q + chunk_q;
      end
    end
  end
endmodule

// File: rtl/lfs_credit.sv
module lfs_credit #(
  parameter int LIMIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               issue,
  input  logic               retire,
  input  logic               run,
  output logic               can_issue,
  output logic [LIMIT_W-1:0] inflight,
  output logic [LIMIT_W-1:0] limit_q,
  output logic               done
);
  logic [LIMIT_W-1:0] cnt_q;
  logic               done_q;
  logic               last_back;

  assign last_back = retire && (cnt_q == LIMIT_W'(1)) && !issue && !run;
  assign can_issue = cnt_q < limit_q;
  assign inflight  = cnt_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      limit_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (start) limit_q <= limit;
      case ({issue, retire})
        2'b10:   cnt_q <= cnt_q + LIMIT_W'(1);
        2'b01:   cnt_q <= cnt_q - LIMIT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
      done_q <= last_back;
    end
  end
endmodule

// File: rtl/line_fetch_seq.sv
module line_fetch_seq
  import lfs_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 16,
  parameter int PITCH_W        = 20,
  parameter int CNT_W          = 12,
  parameter int PORT_BYTES     = 8,
  parameter int MAX_BURST_LOG2 = 4,
  parameter bit COUNT_PLUS_ONE = 1'b0,
  localparam int BYTES_W       = $clog2(PORT_BYTES << MAX_BURST_LOG2) + 1,
  localparam int ECNT_W        = CNT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic                      abort,
  input  logic [ADDR_W-1:0]         base_addr,
  input  logic [LEN_W-1:0]          line_len,
  input  logic signed [PITCH_W-1:0] line_pitch,
  input  logic [CNT_W-1:0]          line_count,
  input  logic [OPTS_W-1:0]         bus_opts,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_addr,
  output logic [BYTES_W-1:0]        req_bytes,
  input  logic                      rsp_valid,
  output logic                      busy,
  output logic [LIMIT_W-1:0]        inflight,
  output logic                      fetch_done,
  output logic                      fifo_flush
);
  logic [FLAG_W-1:0]  flags;
  logic [LIMIT_W-1:0] limit_in, lim_q;
  logic [BYTES_W-1:0] burst_bytes;
  logic [ECNT_W-1:0]  count_eff;
  logic               run, can_issue, start_ok, req_fire, line_end;
  logic               flush_q;
  logic               opts_unused;

  assign flags       = bus_opts[FLAG_LSB +: FLAG_W];
  assign limit_in    = bus_opts[LIMIT_LSB +: LIMIT_W];
  assign opts_unused = ^bus_opts;

  generate
    if (COUNT_PLUS_ONE) begin : g_cnt_inc
      assign count_eff = ECNT_W'(line_count) + ECNT_W'(1);
    end else begin : g_cnt_raw
      assign count_eff = ECNT_W'(line_count);
    end
  endgenerate

  assign start_ok   = frame_start && !run && !abort &&
                      (limit_in != '0) && (line_len != '0);
  assign req_valid  = run && can_issue;
  assign req_fire   = req_valid && req_ready;
  assign busy       = run;
  assign fifo_flush = flush_q;

  lfs_burst_decode #(
    .PORT_BYTES(PORT_BYTES), .MAX_BURST_LOG2(MAX_BURST_LOG2), .BYTES_W(BYTES_W)
  ) u_decode (
    .flags(flags), .burst_bytes(burst_bytes)
  );

  lfs_addr_walker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PITCH_W(PITCH_W),
    .CNT_W(ECNT_W), .BYTES_W(BYTES_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .abort(abort),
    .base(base_addr), .pitch(line_pitch), .count(count_eff),
    .line_len(line_len), .burst_bytes(burst_bytes), .issue(req_fire),
    .run(run), .cur_addr(req_addr), .cur_bytes(req_bytes), .line_end(line_end)
  );

  lfs_credit #(.LIMIT_W(LIMIT_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .limit(limit_in),
    .issue(req_fire), .retire(rsp_valid), .run(run),
    .can_issue(can_issue), .inflight(inflight), .limit_q(lim_q),
    .done(fetch_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= abort;
  end
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker
  import lfs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BYTES_W   = 8,
  parameter int MAX_BYTES = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               abort,
  input logic [OPTS_W-1:0]  bus_opts,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [BYTES_W-1:0] req_bytes,
  input logic               busy,
  input logic [LIMIT_W-1:0] inflight,
  input logic [LIMIT_W-1:0] lim_q,
  input logic               fetch_done,
  input logic               fifo_flush
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  assert_burst_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes != '0) && (int'(req_bytes) <= MAX_BYTES));

  assert_credit_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> inflight < lim_q);

  assert_zero_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !busy && bus_opts[LIMIT_LSB +: LIMIT_W] == '0) |=> !busy);

  assert_abort_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !req_valid && fifo_flush));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> (!busy && inflight == '0));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !abort) |=>
      (req_valid && $stable(req_addr) && $stable(req_bytes)));
endmodule

bind line_fetch_seq lfs_checker #(
  .ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .MAX_BYTES(PORT_BYTES << MAX_BURST_LOG2)
) u_lfs_checker (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .abort(abort),
  .bus_opts(bus_opts), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_bytes(req_bytes), .busy(busy),
  .inflight(inflight), .lim_q(lim_q), .fetch_done(fetch_done),
  .fifo_flush(fifo_flush)
);

// File: tb/line_fetch_seq_bench.sv
`timescale 1ns/1ps
module line_fetch_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        abort = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] line_len = '0;
  logic signed [19:0] line_pitch = '0;
  logic [11:0] line_count = '0;
  logic [31:0] bus_opts = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [7:0]  req_bytes;
  logic        rsp_valid = 1'b0;
  logic        busy;
  logic [3:0]  inflight;
  logic        fetch_done;
  logic        fifo_flush;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] cap_addr [0:63];
  int          cap_bytes [0:63];
  int ncap = 0;
  int pend = 0;
  int irq_cnt = 0;

  always #4 clk = ~clk;

  line_fetch_seq u_line_fetch_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .abort(abort),
    .base_addr(base_addr), .line_len(line_len), .line_pitch(line_pitch),
    .line_count(line_count), .bus_opts(bus_opts), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_bytes(req_bytes),
    .rsp_valid(rsp_valid), .busy(busy), .inflight(inflight),
    .fetch_done(fetch_done), .fifo_flush(fifo_flush)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_capture();
    ncap = 0;
    irq_cnt = 0;
  endtask

  task automatic start_frame(input logic [31:0] b, input int len, input int pitch,
                             input int cnt, input logic [4:0] flags, input logic [3:0] lim);
    base_addr   = b;
    line_len    = 16'(len);
    line_pitch  = 20'(pitch);
    line_count  = 12'(cnt);
    bus_opts    = {20'h0, lim, 3'b000, flags};
    req_ready   = 1'b0;
    rsp_valid   = 1'b0;
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  // mode 0: always ready, mode 1: ready two cycles out of three
  task automatic collect(input int cycles, input bit give_rsp, input int mode);
    for (int i = 0; i < cycles; i++) begin
      bit fire;
      bit back;
      req_ready = (mode == 0) ? 1'b1 : ((i % 3) != 0);
      rsp_valid = give_rsp && (pend > 0);
      fire = req_valid && req_ready;
      back = rsp_valid;
      if (fire && ncap < 64) begin
        cap_addr[ncap]  = req_addr;
        cap_bytes[ncap] = int'(req_bytes);
        ncap++;
      end
      @(posedge clk);
      pend = pend + int'(fire) - int'(back);
      #1;
      if (fetch_done) irq_cnt++;
    end
    req_ready = 1'b0;
    rsp_valid = 1'b0;
  endtask

  task automatic check_seq(input logic [31:0] b, input int len, input int pitch,
                           input int cnt, input int bb, input string tag);
    int k;
    k = 0;
    for (int ln = 0; ln < cnt; ln++) begin
      for (int o = 0; o < len; o += bb) begin
        int sz;
        logic [31:0] ea;
        sz = (len - o < bb) ? len - o : bb;
        ea = b + 32'(ln * pitch) + 32'(o);
        if (k < ncap) begin
          chk(cap_addr[k] == ea, {tag, " addr"}, cap_addr[k], ea);
          chk(cap_bytes[k] == sz, {tag, " bytes"}, cap_bytes[k], sz);
        end
        k++;
      end
    end
    chk(ncap == k, {tag, " request count"}, ncap, k);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
    chk(inflight == 4'd0, "R1 inflight", inflight, 0);
    chk(fetch_done == 1'b0, "R1 fetch_done", fetch_done, 0);
    chk(fifo_flush == 1'b0, "R1 fifo_flush", fifo_flush, 0);
  endtask

  task automatic t_basic();
    clear_capture();
    start_frame(32'h1000, 64, 256, 3, 5'b00000, 4'd4);
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(req_addr == 32'h1000, "R2 first address", req_addr, 32'h1000);
    collect(60, 1'b1, 0);
    check_seq(32'h1000, 64, 256, 3, 128, "R2 single-burst lines");
    chk(irq_cnt == 1, "R9 one completion pulse", irq_cnt, 1);
    chk(inflight == 4'd0, "R9 inflight drained", inflight, 0);
  endtask

  task automatic t_split();
    clear_capture();
    start_frame(32'h2000, 100, 128, 2, 5'b00100, 4'd3);
    collect(120, 1'b1, 1);
    check_seq(32'h2000, 100, 128, 2, 16, "R5 R11 split with stalls");
    chk(irq_cnt == 1, "R9 split completion", irq_cnt, 1);
  endtask

  task automatic t_flags();
    clear_capture();
    start_frame(32'h5000, 200, 256, 1, 5'b00001, 4'd15);
    collect(80, 1'b1, 0);
    check_seq(32'h5000, 200, 256, 1, 8, "R4 flag bit0 one beat");
    clear_capture();
    start_frame(32'h5000, 200, 256, 1, 5'b10010, 4'd15);
    collect(40, 1'b1, 0);
    check_seq(32'h5000, 200, 256, 1, 64, "R4 flag bit4 eight beats");
    clear_capture();
    start_frame(32'h5000, 256, 256, 1, 5'b00000, 4'd15);
    collect(40, 1'b1, 0);
    check_seq(32'h5000, 256, 256, 1, 128, "R4 R5 zero flags exact split");
  endtask

  task automatic t_negative();
    clear_capture();
    start_frame(32'h8000, 32, -512, 3, 5'b00000, 4'd2);
    collect(60, 1'b1, 0);
    check_seq(32'h8000, 32, -512, 3, 128, "R3 negative pitch");
    chk(irq_cnt == 1, "R3 completion after descending walk", irq_cnt, 1);
  endtask

  task automatic t_limit();
    clear_capture();
    start_frame(32'h3000, 64, 64, 2, 5'b01000, 4'd2);
    collect(8, 1'b0, 0);
    chk(ncap == 2, "R6 requests held at limit", ncap, 2);
    chk(inflight == 4'd2, "R6 inflight at limit", inflight, 2);
    chk(req_valid == 1'b0, "R6 req_valid low at limit", req_valid, 0);
    collect(40, 1'b1, 0);
    check_seq(32'h3000, 64, 64, 2, 32, "R6 full walk after credit");
    chk(irq_cnt == 1, "R9 completion after credit", irq_cnt, 1);
  endtask

  task automatic t_idle_starts();
    clear_capture();
    start_frame(32'h6000, 64, 64, 2, 5'b00000, 4'd0);
    chk(busy == 1'b0, "R7 zero limit ignored", busy, 0);
    collect(5, 1'b1, 0);
    chk(ncap == 0, "R7 no request with zero limit", ncap, 0);
    start_frame(32'h6000, 0, 64, 2, 5'b00000, 4'd4);
    chk(busy == 1'b0, "R7 zero length ignored", busy, 0);
    start_frame(32'h6000, 64, 64, 0, 5'b00000, 4'd4);
    chk(busy == 1'b0, "R12 zero lines idle", busy, 0);
    collect(5, 1'b1, 0);
    chk(ncap == 0, "R12 no request for empty frame", ncap, 0);
    chk(irq_cnt == 0, "R12 no completion for empty frame", irq_cnt, 0);
  endtask

  task automatic t_abort();
    clear_capture();
    start_frame(32'h4000, 64, 64, 4, 5'b01000, 4'd8);
    collect(3, 1'b0, 0);
    chk(ncap == 3, "R8 requests before abort", ncap, 3);
    abort = 1'b1;
    @(posedge clk); #1;
    abort = 1'b0;
    chk(busy == 1'b0, "R8 busy after abort", busy, 0);
    chk(req_valid == 1'b0, "R8 req_valid after abort", req_valid, 0);
    chk(fifo_flush == 1'b1, "R8 flush pulse", fifo_flush, 1);
    @(posedge clk); #1;
    chk(fifo_flush == 1'b0, "R8 flush one cycle", fifo_flush, 0);
    collect(10, 1'b0, 0);
    chk(ncap == 3, "R8 no request after abort", ncap, 3);
    chk(irq_cnt == 0, "R9 no completion while pending", irq_cnt, 0);
    collect(20, 1'b1, 0);
    chk(irq_cnt == 1, "R9 completion after abort drain", irq_cnt, 1);
    chk(cap_addr[2] == 32'h4040, "R8 last address before abort", cap_addr[2], 32'h4040);
  endtask

  task automatic t_restart_busy();
    clear_capture();
    start_frame(32'h1000, 32, 64, 2, 5'b00000, 4'd1);
    collect(3, 1'b0, 0);
    start_frame(32'h9000, 32, 64, 2, 5'b00000, 4'd4);
    collect(40, 1'b1, 0);
    check_seq(32'h1000, 32, 64, 2, 128, "R10 start while busy ignored");
    chk(irq_cnt == 1, "R10 single completion", irq_cnt, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_split();
    t_flags();
    t_negative();
    t_limit();
    t_idle_starts();
    t_abort();
    t_restart_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule